// File: doc/BRIEF.md
# Ternary Match Classifier with Priority Select

This block classifies a search key against a table of ternary rules. Each rule holds a value word, a care mask of the same width and a valid flag, and owns one action word. A search compares the key against every rule at once; among the rules that match, the one at the lowest table position wins. The winner's position then selects its action. Software loads rules one at a time through a write port and is expected to place the most specific rules at the lowest positions. For longest-prefix forwarding, that means longer prefixes go first.

A search is requested by raising `srch_en` with a key. Two clock cycles later, `rsp_valid` rises for one cycle. At that point `rsp_hit`, `rsp_idx` and `rsp_action` carry the result. Searches may be issued on every cycle. A rule write issued on the same clock edge as a search is invisible to that search, both in the comparison and in the action word, and is visible to every later search.

Top module: `tcam_classifier`

## Requirements
- R1: While and after reset, `rsp_valid` and `rsp_hit` are 0, and every rule is invalid, so a search issued after reset misses.
- R2: A key bit position whose care-mask bit is 0 matches regardless of the key bit and the stored value bit.
- R3: A key bit position whose care-mask bit is 1 matches only when the key bit equals the stored value bit.
- R4: A rule matches only when all KEY_W bit positions match; a single mismatching cared bit removes the rule.
- R5: When several valid rules match, the reported index is the lowest matching index.
- R6: A rule written with `wr_valid`=0 never matches. A response with no match reports `rsp_hit`=0, `rsp_idx`=0 and `rsp_action`=0.
- R7: On a hit, `rsp_action` is the action word last written to the winning index.
- R8: `rsp_valid` is 1 exactly in the cycle two clock edges after the edge that sampled `srch_en`=1, and 0 otherwise.
- R9: A write on the same edge as a search affects neither that search's match nor its action; it applies to searches sampled on later edges.
- R10: With a /24 rule for 1.23.11.0 at index 8 and a /16 rule for 1.23.0.0 at index 9 (mask upper bits 1), key 1.23.11.3 hits index 8 and key 1.23.255.1 hits index 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one rule this cycle |
| wr_idx | input | IDX_W | Rule position to write |
| wr_valid | input | 1 | Valid flag stored with the rule |
| wr_value | input | KEY_W | Value word of the rule |
| wr_mask | input | KEY_W | Care mask, 1 = bit compared |
| wr_action | input | ACT_W | Action word for the rule |
| srch_en | input | 1 | Issue a search this cycle |
| srch_key | input | KEY_W | Key to classify |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_hit | output | 1 | Some valid rule matched |
| rsp_idx | output | IDX_W | Lowest matching rule position |
| rsp_action | output | ACT_W | Action of the winning rule |

## Verification
A corrupted rule value, mask or valid flag causes a wrong hit, a wrong index or a miss two cycles after the first search that touches that rule. A fault in the priority chain only appears when two rules overlap, so the stimulus deliberately stacks overlapping prefixes. A stale or early action word only shows when a write and a search share an edge, or follow each other immediately, so those pairings are exercised directly. The reference model recomputes every response from its own rule table, so a divergence is reported in the same cycle the response appears.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    localparam int TCAM_ENTRIES = 16;
    localparam int TCAM_KEY_W   = 32;
    localparam int TCAM_ACT_W   = 8;
    localparam int TCAM_MAX_W   = 64;

    typedef logic [TCAM_MAX_W-1:0] wide_word_t;

    // Ternary compare on a zero-extended word: cared bits must agree.
    function automatic logic ternary_ok(input wide_word_t value,
                                        input wide_word_t care,
                                        input wide_word_t key);
        return ((value ^ key) & care) == '0;
    endfunction

endpackage

// File: rtl/tcam_entry_array.sv
module tcam_entry_array
    import tcam_pkg::*;
#(
    parameter int ENTRIES = TCAM_ENTRIES,
    parameter int KEY_W   = TCAM_KEY_W,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic               wr_valid,
    input  logic [KEY_W-1:0]   wr_value,
    input  logic [KEY_W-1:0]   wr_mask,
    input  logic [KEY_W-1:0]   key,
    output logic [ENTRIES-1:0] match_vec
);

    typedef struct packed {
        logic             live;
        logic [KEY_W-1:0] value;
        logic [KEY_W-1:0] care;
    } rule_t;

    rule_t rules_q [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_rule
        logic sel;
        assign sel = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                rules_q[g].live <= 1'b0;
            end else if (sel) begin
                rules_q[g].live <= wr_valid;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst && sel) begin
                rules_q[g].value <= wr_value;
                rules_q[g].care  <= wr_mask;
            end
        end

        assign match_vec[g] = rules_q[g].live &&
                              ternary_ok(wide_word_t'(rules_q[g].value),
                                         wide_word_t'(rules_q[g].care),
                                         wide_word_t'(key));
    end

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] req,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    // Scan from the top so the lowest set position is the last assignment.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tcam_action_ram.sv
module tcam_action_ram #(
    parameter int ENTRIES = 16,
    parameter int ACT_W   = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ACT_W-1:0] wr_data,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ACT_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ACT_W-1:0] mem [DEPTH];

    // Posted write: lands one edge late, so a search whose read happens on
    // that edge still sees the older word.
    logic             pw_en;
    logic [IDX_W-1:0] pw_idx;
    logic [ACT_W-1:0] pw_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            pw_en   <= 1'b0;
            pw_idx  <= '0;
            pw_data <= '0;
        end else begin
            pw_en   <= wr_en;
            pw_idx  <= wr_idx;
            pw_data <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && pw_en) begin
            mem[pw_idx] <= pw_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem[rd_idx];
        end
    end

endmodule

// File: rtl/tcam_classifier.sv
module tcam_classifier
    import tcam_pkg::*;
#(
    parameter int ENTRIES = TCAM_ENTRIES,
    parameter int KEY_W   = TCAM_KEY_W,
    parameter int ACT_W   = TCAM_ACT_W,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_valid,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic [ACT_W-1:0] wr_action,
    input  logic             srch_en,
    input  logic [KEY_W-1:0] srch_key,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic [IDX_W-1:0] rsp_idx,
    output logic [ACT_W-1:0] rsp_action
);

    typedef struct packed {
        logic             busy;
        logic             hit;
        logic [IDX_W-1:0] idx;
    } stage_t;

    logic [ENTRIES-1:0] match_vec;
    logic               enc_found;
    logic [IDX_W-1:0]   enc_idx;
    logic [ACT_W-1:0]   act_word;
    stage_t             s1_q;
    stage_t             s2_q;

    tcam_entry_array #(
        .ENTRIES (ENTRIES),
        .KEY_W   (KEY_W),
        .IDX_W   (IDX_W)
    ) u_array (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_valid  (wr_valid),
        .wr_value  (wr_value),
        .wr_mask   (wr_mask),
        .key       (srch_key),
        .match_vec (match_vec)
    );

    tcam_prio_enc #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_enc (
        .req   (match_vec),
        .found (enc_found),
        .idx   (enc_idx)
    );

    tcam_action_ram #(
        .ENTRIES (ENTRIES),
        .ACT_W   (ACT_W),
        .IDX_W   (IDX_W)
    ) u_act (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_action),
        .rd_en   (s1_q.busy && s1_q.hit),
        .rd_idx  (s1_q.idx),
        .rd_data (act_word)
    );

    // Stage 1: compare and encode.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q.busy <= srch_en;
            s1_q.hit  <= srch_en && enc_found;
            s1_q.idx  <= (srch_en && enc_found) ? enc_idx : '0;
        end
    end

    // Stage 2: action read completes alongside the forwarded result.
    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q <= s1_q;
        end
    end

    assign rsp_valid  = s2_q.busy;
    assign rsp_hit    = s2_q.hit;
    assign rsp_idx    = s2_q.idx;
    assign rsp_action = s2_q.hit ? act_word : '0;

endmodule

// File: rtl/tcam_classifier_chk.sv
module tcam_classifier_chk #(
    parameter int ENTRIES = 16,
    parameter int ACT_W   = 8,
    parameter int IDX_W   = $clog2(ENTRIES)
) (
    input logic               clk,
    input logic               rst,
    input logic               srch_en,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [IDX_W-1:0]   rsp_idx,
    input logic [ACT_W-1:0]   rsp_action,
    input logic [ENTRIES-1:0] match_vec,
    input logic               enc_found,
    input logic [IDX_W-1:0]   enc_idx
);

    logic [1:0] age_q;
    logic       srch_d1;
    logic       srch_d2;
    logic [ENTRIES-1:0] below;

    always_ff @(posedge clk) begin
        if (rst) begin
            age_q   <= '0;
            srch_d1 <= 1'b0;
            srch_d2 <= 1'b0;
        end else begin
            if (age_q != 2'd3) age_q <= age_q + 2'd1;
            srch_d1 <= srch_en;
            srch_d2 <= srch_d1;
        end
    end

    always_comb begin
        below = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) < enc_idx) below[i] = 1'b1;
        end
    end

    // R8
    rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (age_q >= 2'd2) |-> (rsp_valid == srch_d2));

    // R6
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_hit) |-> (rsp_idx == '0 && rsp_action == '0));

    // R8
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_hit |-> rsp_valid);

    // R5
    prio_winner_chk: assert property (@(posedge clk) disable iff (rst)
        enc_found |-> match_vec[enc_idx]);

    // R5
    prio_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        enc_found |-> ((match_vec & below) == '0));

    // R6
    found_iff_any_chk: assert property (@(posedge clk) disable iff (rst)
        enc_found == (match_vec != '0));

endmodule

bind tcam_classifier tcam_classifier_chk #(
    .ENTRIES (ENTRIES),
    .ACT_W   (ACT_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .srch_en    (srch_en),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_idx    (rsp_idx),
    .rsp_action (rsp_action),
    .match_vec  (match_vec),
    .enc_found  (enc_found),
    .enc_idx    (enc_idx)
);

// File: tb/tcam_classifier_tb.sv
`timescale 1ns/1ps
module tcam_classifier_tb;

    localparam int N  = 16;
    localparam int KW = 32;
    localparam int AW = 8;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [IW-1:0] wr_idx;
    logic          wr_valid;
    logic [KW-1:0] wr_value;
    logic [KW-1:0] wr_mask;
    logic [AW-1:0] wr_action;
    logic          srch_en;
    logic [KW-1:0] srch_key;
    logic          rsp_valid;
    logic          rsp_hit;
    logic [IW-1:0] rsp_idx;
    logic [AW-1:0] rsp_action;

    always #4 clk = ~clk;

    tcam_classifier #(.ENTRIES(N), .KEY_W(KW), .ACT_W(AW), .IDX_W(IW)) u_dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
        .wr_value(wr_value), .wr_mask(wr_mask), .wr_action(wr_action),
        .srch_en(srch_en), .srch_key(srch_key),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_idx(rsp_idx), .rsp_action(rsp_action)
    );

    // Behavioural reference table
    logic [KW-1:0] m_val [N];
    logic [KW-1:0] m_msk [N];
    bit            m_vld [N];
    logic [AW-1:0] m_act [N];

    typedef struct {
        bit          v;
        bit          h;
        int          idx;
        logic [AW-1:0] act;
    } exp_t;

    exp_t  e1, e2;
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "R1";

    function automatic exp_t predict(input logic [KW-1:0] key);
        exp_t r;
        r.v = 1; r.h = 0; r.idx = 0; r.act = '0;
        for (int i = 0; i < N; i++) begin
            if (!r.h && m_vld[i]) begin
                bit ok = 1;
                for (int b = 0; b < KW; b++)
                    if (m_msk[i][b] && (m_val[i][b] != key[b])) ok = 0;
                if (ok) begin
                    r.h = 1; r.idx = i; r.act = m_act[i];
                end
            end
        end
        return r;
    endfunction

    task automatic compare();
        n_vec++;
        if (!e2.v) begin
            if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
                n_bad++;
                $display("FAIL %s: idle cycle valid=%0b hit=%0b expected 0/0",
                         tag, rsp_valid, rsp_hit);
            end
        end else if (rsp_valid !== 1'b1 || rsp_hit !== e2.h ||
                     int'(rsp_idx) != e2.idx || rsp_action !== e2.act) begin
            n_bad++;
            $display("FAIL %s: got v=%0b h=%0b idx=%0d act=%h expected v=1 h=%0b idx=%0d act=%h",
                     tag, rsp_valid, rsp_hit, rsp_idx, rsp_action, e2.h, e2.idx, e2.act);
        end
    endtask

    task automatic step(input bit we, input int wi, input bit wv,
                        input logic [KW-1:0] wval, input logic [KW-1:0] wmsk,
                        input logic [AW-1:0] wact,
                        input bit se, input logic [KW-1:0] skey);
        exp_t now;
        wr_en = we; wr_idx = IW'(wi); wr_valid = wv;
        wr_value = wval; wr_mask = wmsk; wr_action = wact;
        srch_en = se; srch_key = skey;
        now.v = 0; now.h = 0; now.idx = 0; now.act = '0;
        if (se && !rst) now = predict(skey);
        if (we && !rst) begin
            m_val[wi] = wval; m_msk[wi] = wmsk;
            m_vld[wi] = wv;   m_act[wi] = wact;
        end
        if (rst) for (int i = 0; i < N; i++) m_vld[i] = 0;
        @(posedge clk);
        e2 = e1;
        e1 = now;
        if (rst) begin e1.v = 0; e2.v = 0; end
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        step(0, 0, 0, '0, '0, '0, 0, '0);
    endtask

    task automatic wr(input int i, input bit v, input logic [KW-1:0] val,
                      input logic [KW-1:0] msk, input logic [AW-1:0] act);
        step(1, i, v, val, msk, act, 0, '0);
    endtask

    task automatic sr(input logic [KW-1:0] key);
        step(0, 0, 0, '0, '0, '0, 1, key);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        e1.v = 0; e2.v = 0;
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 0; m_val[i] = '0; m_msk[i] = '0; m_act[i] = '0;
        end
        rst = 1;
        @(negedge clk);
        // R1: reset holds outputs low, searches during reset are dropped
        tag = "R1";
        step(0, 0, 0, '0, '0, '0, 1, 32'h0);
        step(0, 0, 0, '0, '0, '0, 1, 32'h0);
        rst = 0;
        sr(32'h0000_0000); sr(32'hFFFF_FFFF); idle(); idle();

        // R2: masked-off bits are don't care
        tag = "R2";
        wr(5, 1, 32'h0A00_0000, 32'hFF00_0000, 8'h55);
        sr(32'h0A12_3456); sr(32'h0AFF_FFFF); sr(32'h0A00_0000); idle(); idle();

        // R3: cared bits must equal
        tag = "R3";
        sr(32'h0B00_0000); sr(32'h8A00_0000); idle(); idle();

        // R5: lowest index wins among overlapping rules
        tag = "R5";
        wr(2, 1, 32'h0A12_3456, 32'hFFFF_FFFF, 8'h22);
        sr(32'h0A12_3456); idle(); idle();

        // R4: one mismatching cared bit drops the exact rule
        tag = "R4";
        sr(32'h0A12_3457); sr(32'h8A12_3456); idle(); idle();

        // R6: invalidated rule never matches; miss reports zeros
        tag = "R6";
        wr(2, 0, 32'h0A12_3456, 32'hFFFF_FFFF, 8'h22);
        sr(32'h0A12_3456); sr(32'h7700_0000); idle(); idle();

        // R7: action follows the winning index after a rewrite
        tag = "R7";
        wr(5, 1, 32'h0A00_0000, 32'hFF00_0000, 8'hC3);
        sr(32'h0A00_0001); idle(); idle();

        // R9: same-edge write is invisible to that search, visible next
        tag = "R9";
        step(1, 1, 1, 32'h0A12_3456, 32'hFFFF_FFFF, 8'h11, 1, 32'h0A12_3456);
        sr(32'h0A12_3456);
        step(1, 5, 1, 32'h0A00_0000, 32'hFF00_0000, 8'h99, 1, 32'h0A00_0777);
        sr(32'h0A00_0777);
        step(1, 1, 0, '0, '0, 8'h00, 1, 32'h0A12_3456);
        sr(32'h0A12_3456); idle(); idle();

        // R10: longest prefix placed first wins
        tag = "R10";
        wr(8, 1, 32'h0117_0B00, 32'hFFFF_FF00, 8'h24);
        wr(9, 1, 32'h0117_0000, 32'hFFFF_0000, 8'h16);
        sr(32'h0117_0B03); sr(32'h0117_FF01); sr(32'h0118_0B03); idle(); idle();

        // R8: back-to-back and gapped searches
        tag = "R8";
        sr(32'h0117_0B03); sr(32'h0A00_0000); idle(); sr(32'h0117_0001);
        idle(); idle(); idle();

        // R5: random overlapping prefixes against the model
        tag = "R5";
        for (int k = 0; k < 600; k++) begin
            bit we = ($urandom % 3) == 0;
            int wi = $urandom % N;
            int sh = $urandom % 33;
            logic [KW-1:0] msk = (sh == 32) ? '0 : (32'hFFFF_FFFF << sh);
            logic [KW-1:0] val = $urandom;
            logic [KW-1:0] key = $urandom;
            int pick = $urandom % N;
            if ($urandom % 4 != 0) key = m_val[pick] ^ (32'h0000_00FF & $urandom);
            step(we, wi, ($urandom % 4) != 0, val, msk, 8'($urandom),
                 ($urandom % 4) != 0, key);
        end
        idle(); idle();

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule